// File: doc/BRIEF.md
# Page Write Commit Controller

This block sits behind a two-wire serial memory slave engine and owns the write path into a byte-wide storage array. During a write transaction the engine hands it a start address, then each data byte as it is received. The block holds those bytes in a page buffer of eight slots. The upper address bits fix which page is written. Only the low three bits step from byte to byte, and they wrap inside the page.

When the transaction ends with a stop condition, the block samples the write-protect input once. If protection is off, it raises `busy` and counts out a self-timed programming interval. It then copies every received slot into the array at one byte per clock and drops `busy`. While `busy` is high, every new address, byte or stop is refused. A protected stop discards the buffer at once, with no busy period. A repeated start also discards the buffer.

The array starts with every location at FFh. The engine reads the array through a registered read port.

Top module: `pw_page_commit`

## Requirements
- R1: After power-up every array location reads FFh. `rd_data` shows the location given on `rd_addr` one clock after that address is presented.
- R2: The page is fixed by address bits above bit 2 of the loaded start address. Bits 2..0 select the slot, and that slot number increments by one after each byte. Slot 7 is followed by slot 0 of the same page, and the next page is never touched.
- R3: A write of fewer than eight bytes changes only the locations that received a byte. All other locations in the page keep their contents.
- R4: When more than eight bytes arrive, a later byte replaces the earlier byte at the same wrapped slot. Only the last value for each slot is committed.
- R5: A commit starts only on a stop that follows at least one data byte since the last address load. A stop with no data does nothing. A repeated start discards the collected bytes, so a later stop commits nothing.
- R6: If `wp_in` is 1 on the stop cycle, no location changes and `busy` stays 0. The block then takes a new write at once.
- R7: `wp_in` is sampled only on the stop cycle. Changing it while `busy` is high does not cancel or change the commit.
- R8: `busy` rises on the clock that samples the stop. It stays high for exactly WR_CYCLES + 8 clocks. The array still holds its old data during the timed interval, and the new data is readable once `busy` is low.
- R9: Address loads, data bytes and stops presented while `busy` is high are ignored. They change no location and start no further busy period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (does not clear the array) |
| addr_vld | input | 1 | One-cycle pulse: load a new start address |
| addr_in | input | ADDR_W | Start address carried by `addr_vld` |
| byte_vld | input | 1 | One-cycle pulse: one received data byte |
| byte_in | input | 8 | Data byte carried by `byte_vld` |
| stop_evt | input | 1 | One-cycle pulse: stop condition seen on the bus |
| rstart_evt | input | 1 | One-cycle pulse: repeated start seen on the bus |
| wp_in | input | 1 | Write-protect level, sampled on the stop cycle |
| rd_addr | input | ADDR_W | Array read address |
| busy | output | 1 | Programming interval or array update in progress |
| rd_data | output | 8 | Registered array read data |

## Verification
The hardest situations to reach are the ones where write protection or a new transaction overlaps a cycle that has already started. One is `wp_in` rising after a stop was accepted. Another is a full address, byte and stop sequence arriving while `busy` is high. The stimulus drives these inputs while `busy` is still high, then reads the affected locations afterwards. It also watches that no second busy period follows. Wrap-around is reached by starting near the end of a page, and overrun by sending ten bytes to one page. Both are checked location by location against a model built from the requirements.

// File: rtl/pw_pkg.sv
package pw_pkg;
  typedef enum logic [1:0] {
    PW_IDLE  = 2'd0,
    PW_WAIT  = 2'd1,
    PW_FLUSH = 2'd2
  } pw_state_e;

  typedef logic [7:0] pw_byte_t;
endpackage

// File: rtl/pw_page_buf.sv
module pw_page_buf #(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic [ADDR_W-1:0]        load_addr,
  input  logic                     wr,
  input  pw_pkg::pw_byte_t         wr_data,
  input  logic                     clear,
  input  logic [PAGE_W-1:0]        rd_idx,
  output pw_pkg::pw_byte_t         rd_byte,
  output logic [ADDR_W-PAGE_W-1:0] page_base,
  output logic [(1<<PAGE_W)-1:0]   mask
);
  localparam int SLOTS  = 1 << PAGE_W;
  localparam int BASE_W = ADDR_W - PAGE_W;

  logic [PAGE_W-1:0] ofs_q;
  logic [BASE_W-1:0] base_q;
  pw_pkg::pw_byte_t  slot_q [SLOTS];

  // Slot pointer steps only in the low bits; the page base holds.
  always_ff @(posedge clk) begin
    if (rst) begin
      ofs_q  <= '0;
      base_q <= '0;
    end else if (load) begin
      ofs_q  <= load_addr[PAGE_W-1:0];
      base_q <= load_addr[ADDR_W-1:PAGE_W];
    end else if (wr) begin
      ofs_q  <= ofs_q + 1'b1;
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr && ofs_q == PAGE_W'(g)) slot_q[g] <= wr_data;
    end
    always_ff @(posedge clk) begin
      if (rst || clear || load)          mask[g] <= 1'b0;
      else if (wr && ofs_q == PAGE_W'(g)) mask[g] <= 1'b1;
    end
  end

  assign rd_byte   = slot_q[rd_idx];
  assign page_base = base_q;

  // R2: page base moves only on an address load
  p_base_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(base_q));
endmodule

// File: rtl/pw_cycle_timer.sv
module pw_cycle_timer #(
  parameter int WR_CYCLES = 500000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic done
);
  localparam int CNT_W = $clog2(WR_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WR_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start) begin
      cnt_q <= '0;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == LAST) run_q <= 1'b0;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done = run_q && (cnt_q == LAST);

  // R8: the count never passes the interval length
  p_count_bound_r8: assert property (@(posedge clk) disable iff (rst)
    run_q |-> cnt_q <= LAST);
endmodule

// File: rtl/pw_array.sv
module pw_array #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  pw_pkg::pw_byte_t  wdata,
  input  logic [ADDR_W-1:0] raddr,
  output pw_pkg::pw_byte_t  rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  pw_pkg::pw_byte_t mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pw_page_commit.sv
module pw_page_commit #(
  parameter int ADDR_W    = 8,
  parameter int PAGE_W    = 3,
  parameter int WR_CYCLES = 500000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_vld,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              byte_vld,
  input  logic [7:0]        byte_in,
  input  logic              stop_evt,
  input  logic              rstart_evt,
  input  logic              wp_in,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              busy,
  output logic [7:0]        rd_data
);
  import pw_pkg::*;

  localparam int SLOTS  = 1 << PAGE_W;
  localparam int BASE_W = ADDR_W - PAGE_W;

  pw_state_e          state_q;
  logic [PAGE_W-1:0]  idx_q;
  logic [BASE_W-1:0]  page_base;
  logic [SLOTS-1:0]   mask;
  pw_byte_t           slot_byte;
  logic               tmr_done;

  logic accept, ld, wr, go, drop, flush_last, buf_clear, arr_we;

  assign accept     = (state_q == PW_IDLE);
  assign ld         = accept && addr_vld;
  assign wr         = accept && byte_vld;
  assign go         = accept && stop_evt && (|mask) && !wp_in;
  assign drop       = accept && (rstart_evt || (stop_evt && wp_in));
  assign flush_last = (state_q == PW_FLUSH) && (idx_q == PAGE_W'(SLOTS - 1));
  assign buf_clear  = drop || flush_last;
  assign arr_we     = (state_q == PW_FLUSH) && mask[idx_q];

  pw_page_buf #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_buf (
    .clk       (clk),
    .rst       (rst),
    .load      (ld),
    .load_addr (addr_in),
    .wr        (wr),
    .wr_data   (byte_in),
    .clear     (buf_clear),
    .rd_idx    (idx_q),
    .rd_byte   (slot_byte),
    .page_base (page_base),
    .mask      (mask)
  );

  pw_cycle_timer #(.WR_CYCLES(WR_CYCLES)) u_tmr (
    .clk   (clk),
    .rst   (rst),
    .start (go),
    .done  (tmr_done)
  );

  pw_array #(.ADDR_W(ADDR_W)) u_arr (
    .clk   (clk),
    .we    (arr_we),
    .waddr ({page_base, idx_q}),
    .wdata (slot_byte),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PW_IDLE;
      idx_q   <= '0;
      busy    <= 1'b0;
    end else begin
      case (state_q)
        PW_IDLE: if (go) begin
          state_q <= PW_WAIT;
          busy    <= 1'b1;
        end
        PW_WAIT: if (tmr_done) begin
          state_q <= PW_FLUSH;
          idx_q   <= '0;
        end
        PW_FLUSH: begin
          idx_q <= idx_q + 1'b1;
          if (flush_last) begin
            state_q <= PW_IDLE;
            busy    <= 1'b0;
          end
        end
        default: state_q <= PW_IDLE;
      endcase
    end
  end

  // R8: an accepted unprotected stop with data raises busy next clock
  p_busy_after_stop_r8: assert property (@(posedge clk) disable iff (rst)
    (!busy && stop_evt && (|mask) && !wp_in) |=> busy);

  // R6: a protected stop never starts a busy period
  p_wp_nobusy_r6: assert property (@(posedge clk) disable iff (rst)
    (!busy && stop_evt && wp_in) |=> !busy);

  // R8: the array is written only inside the busy period
  p_write_only_busy_r8: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> busy);

  // R9: the collected slots are frozen while a cycle runs
  p_mask_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && !flush_last) |=> $stable(mask));

  // R5: nothing is left pending once a commit finishes
  p_clear_after_commit_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (mask == '0));
endmodule

// File: tb/test_pw_page_commit.sv
module test_pw_page_commit;
  localparam int AW  = 8;
  localparam int WRC = 40;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          addr_vld = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic          byte_vld = 1'b0;
  logic [7:0]    byte_in = '0;
  logic          stop_evt = 1'b0;
  logic          rstart_evt = 1'b0;
  logic          wp_in = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic          busy;
  logic [7:0]    rd_data;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  pw_page_commit #(.ADDR_W(AW), .PAGE_W(3), .WR_CYCLES(WRC)) i_pw_page_commit (
    .clk(clk), .rst(rst), .addr_vld(addr_vld), .addr_in(addr_in),
    .byte_vld(byte_vld), .byte_in(byte_in), .stop_evt(stop_evt),
    .rstart_evt(rstart_evt), .wp_in(wp_in), .rd_addr(rd_addr),
    .busy(busy), .rd_data(rd_data)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic send_addr(input logic [AW-1:0] a);
    @(negedge clk); addr_vld = 1'b1; addr_in = a;
    @(negedge clk); addr_vld = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] d);
    @(negedge clk); byte_vld = 1'b1; byte_in = d;
    @(negedge clk); byte_vld = 1'b0;
  endtask

  task automatic send_stop();
    @(negedge clk); stop_evt = 1'b1;
    @(negedge clk); stop_evt = 1'b0;
  endtask

  task automatic send_rstart();
    @(negedge clk); rstart_evt = 1'b1;
    @(negedge clk); rstart_evt = 1'b0;
  endtask

  task automatic read_mem(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk); rd_addr = a;
    @(negedge clk); d = rd_data;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic expect_mem(input string req, input logic [AW-1:0] a, input logic [7:0] e);
    logic [7:0] d;
    read_mem(a, d);
    chk(req, int'(d), int'(e));
  endtask

  // R1: reset state and erased array
  task automatic t_reset();
    chk("R1 busy after reset", int'(busy), 0);
    expect_mem("R1 erased 00", 8'h00, 8'hFF);
    expect_mem("R1 erased 5A", 8'h5A, 8'hFF);
    expect_mem("R1 erased FF", 8'hFF, 8'hFF);
  endtask

  // R3 and R8: single byte, old data held during timing
  task automatic t_single();
    logic [7:0] d;
    send_addr(8'h12); send_byte(8'hA5); send_stop();
    chk("R8 busy after stop", int'(busy), 1);
    read_mem(8'h12, d);
    chk("R8 old data during timing", int'(d), 8'hFF);
    wait_idle();
    expect_mem("R3 written byte", 8'h12, 8'hA5);
    expect_mem("R3 neighbour above", 8'h13, 8'hFF);
    expect_mem("R3 neighbour below", 8'h11, 8'hFF);
  endtask

  // R2: wrap inside the page
  task automatic t_wrap();
    send_addr(8'h2E);
    send_byte(8'h11); send_byte(8'h22); send_byte(8'h33); send_byte(8'h44);
    send_stop(); wait_idle();
    expect_mem("R2 slot 6", 8'h2E, 8'h11);
    expect_mem("R2 slot 7", 8'h2F, 8'h22);
    expect_mem("R2 wrapped slot 0", 8'h28, 8'h33);
    expect_mem("R2 wrapped slot 1", 8'h29, 8'h44);
    expect_mem("R2 next page untouched", 8'h30, 8'hFF);
    expect_mem("R3 unsent slot 2", 8'h2A, 8'hFF);
  endtask

  // R4: ten bytes into one page
  task automatic t_overrun();
    send_addr(8'h40);
    for (int i = 0; i < 10; i++) send_byte(8'(i * 3 + 1));
    send_stop(); wait_idle();
    expect_mem("R4 slot 0 last wins", 8'h40, 8'd25);
    expect_mem("R4 slot 1 last wins", 8'h41, 8'd28);
    expect_mem("R4 slot 2 kept", 8'h42, 8'd7);
    expect_mem("R4 slot 7 kept", 8'h47, 8'd22);
  endtask

  // R5: no data or repeated start commits nothing
  task automatic t_nocommit();
    send_addr(8'h50); send_stop();
    chk("R5 stop without data", int'(busy), 0);
    send_addr(8'h50); send_byte(8'h77); send_rstart(); send_stop();
    chk("R5 stop after repeated start", int'(busy), 0);
    expect_mem("R5 location unchanged", 8'h50, 8'hFF);
  endtask

  // R6: protected stop discards, then ready at once
  task automatic t_protect();
    send_addr(8'h60); send_byte(8'h99);
    wp_in = 1'b1; send_stop(); wp_in = 1'b0;
    chk("R6 no busy when protected", int'(busy), 0);
    expect_mem("R6 protected location", 8'h60, 8'hFF);
    send_addr(8'h61); send_byte(8'h5C); send_stop();
    chk("R6 ready after protected stop", int'(busy), 1);
    wait_idle();
    expect_mem("R6 following write", 8'h61, 8'h5C);
  endtask

  // R7 and R8: wp raised mid-cycle, busy length
  task automatic t_wp_late();
    int n = 0;
    send_addr(8'h70); send_byte(8'hC3); send_stop();
    wp_in = 1'b1;
    while (busy) begin n++; @(negedge clk); end
    wp_in = 1'b0;
    chk("R8 busy length", n, WRC + 8);
    expect_mem("R7 commit despite late wp", 8'h70, 8'hC3);
  endtask

  // R9: whole transaction during busy is ignored
  task automatic t_busy_ignore();
    send_addr(8'h80); send_byte(8'h01); send_stop();
    send_addr(8'h90); send_byte(8'hEE); send_stop();
    chk("R9 still busy", int'(busy), 1);
    wait_idle();
    repeat (3) @(negedge clk);
    chk("R9 no second busy period", int'(busy), 0);
    expect_mem("R9 ignored location", 8'h90, 8'hFF);
    expect_mem("R9 first write kept", 8'h80, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_single();
    t_wrap();
    t_overrun();
    t_nocommit();
    t_protect();
    t_wp_late();
    t_busy_ignore();
    done = 1'b1;
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end
endmodule